// File: doc/BRIEF.md
# Guarded Nonvolatile Byte-Store Write Controller

This block sits between a processor register bus and a byte-wide nonvolatile data array. Software sees four byte registers: a control register, a write-only unlock key register, an address register and a data register. Reads are started with a strobe bit and finish in one cycle. Writes are started with a start bit. A write is accepted only when the enable bit is set, a two-byte key sequence has just been written, and the power-up hold-off window after reset has ended. While the array is programming, the start bit reads back as busy, so software can poll it until the write is done.

A second, external programming port can also read and write the array. It is refused whenever the code-protect input is high, while the processor side keeps full access. The array is a behavioural model with a write latency of `WR_LAT` clock cycles. Address and data are captured when a write starts.

Register offsets on `bus_sel`: 0 control, 1 key, 2 address, 3 data. Control bits: bit 0 write enable, bit 1 read strobe, bit 2 start/busy, bit 3 error flag, bits 5:4 memory select.

Top module: `nvm_ctl_top`

## Requirements
- R1: After reset the control, address and data registers all read 0x00, so the write-enable bit (bit 0) and the error flag (bit 3) are clear.
- R2: For the first `PWRT_CYC` cycles after reset, a start request writes nothing to the array and sets the error flag. After the window, the same sequence is accepted.
- R3: Writing 0x55 and then 0xAA to the key register (offset 1), and then writing the control register with bit 0 and bit 2 both set, programs the data register byte into the array at the address register's location.
- R4: The key sequence is broken by any key byte other than the expected next one, or by any write to the address or data register in between. It is used up by any write to the control register.
- R5: A start request made with bit 0 clear, or without a complete key sequence, changes no array byte and sets the error flag. A control write with bit 3 at 0 that makes no failed start clears the flag.
- R6: Bit 2 reads 1 for `WR_LAT` cycles after a write starts and then clears by itself. Start requests made while it is 1 are ignored and do not set the error flag.
- R7: Writing the control register with bit 1 set loads the array byte at the address register into the data register. Bit 1 always reads back as 0.
- R8: When the select field (bits 5:4) is not 00, read-strobe and start requests have no effect and do not set the error flag. The field reads back as written.
- R9: Address and data are captured when a write starts. Changing either register while busy does not change what is programmed, or where.
- R10: While `code_protect` is 1, external read and write pulses get `xp_refused` one cycle later, with no `xp_ack` and no array change. Processor-side reads and writes still work.
- R11: While `code_protect` is 0, an external read pulse returns the addressed byte on `xp_rdata` with `xp_ack` one cycle later. An external write needs no key sequence and is acknowledged. It is refused while the array is busy.
- R12: The key register always reads back as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational from `bus_sel`) |
| code_protect | input | 1 | Blocks the external programming port when 1 |
| xp_rd | input | 1 | External read pulse |
| xp_wr | input | 1 | External write pulse |
| xp_addr | input | ADDR_W | External array address |
| xp_wdata | input | 8 | External write byte |
| xp_rdata | output | 8 | External read result |
| xp_ack | output | 1 | External request accepted (one cycle after the pulse) |
| xp_refused | output | 1 | External request refused (one cycle after the pulse) |

## Verification
A key sequencer stuck armed, or one that fails to clear on a stray write, shows up as a busy bit rising on the next control write. Such a write should instead have set the error flag. A stuck-low sequencer shows up as an error flag where busy was expected. A wrong hold-off counter shows up as a write accepted, or refused, in the first control write after reset or after the window ends. Faults in latching or in the busy counter appear `WR_LAT` cycles later, as the wrong byte at a read-back or as a busy bit that clears too early or too late when polled.

// File: rtl/nvm_ctl_pkg.sv
// Shared constants and types for the guarded byte-store controller.
// Assumes an 8-bit register bus with four register offsets.
package nvm_ctl_pkg;
    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_HALF  = 2'd1,
        KEY_ARMED = 2'd2
    } key_state_e;

    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_KEY  = 2'd1;
    localparam logic [1:0] OFS_ADDR = 2'd2;
    localparam logic [1:0] OFS_DATA = 2'd3;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    localparam int B_WEN  = 0;
    localparam int B_RD   = 1;
    localparam int B_GO   = 2;
    localparam int B_ERR  = 3;
    localparam int B_SELL = 4;
    localparam int B_SELH = 5;
endpackage

// File: rtl/nvm_pwrt.sv
// Power-up hold-off timer: counts HOLD_CYC cycles after reset, then holds done.
// Assumes the count never needs to restart without a reset.
module nvm_pwrt #(
    parameter int HOLD_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(HOLD_CYC + 2);

    logic [CW-1:0] cnt_q;

    // Count up from reset and stop at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q != CW'(HOLD_CYC))
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == CW'(HOLD_CYC));
endmodule

// File: rtl/nvm_key_seq.sv
// Two-byte key sequencer: arms after KEY_FIRST then KEY_SECOND are written to
// the key register. Assumes other_wr/consume mark any other register write.
module nvm_key_seq
    import nvm_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    input  logic       other_wr,
    input  logic       consume,
    output logic       armed
);
    key_state_e st_q;

    // Advance on the correct key byte, fall back to idle on anything else.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= KEY_IDLE;
        else if (other_wr || consume)
            st_q <= KEY_IDLE;
        else if (key_wr) begin
            if (key_byte == KEY_FIRST)
                st_q <= KEY_HALF;
            else if (key_byte == KEY_SECOND && st_q == KEY_HALF)
                st_q <= KEY_ARMED;
            else
                st_q <= KEY_IDLE;
        end
    end

    assign armed = (st_q == KEY_ARMED);

    // R3
    armed_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(key_wr && key_byte == KEY_SECOND));
endmodule

// File: rtl/nvm_array_model.sv
// Behavioural byte array with a fixed write latency and two async read ports.
// Assumes wr_start is only raised while busy is low; resets to erased (all ones).
module nvm_array_model #(
    parameter int ADDR_W = 8,
    parameter int WR_LAT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              busy,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [7:0]        rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [7:0]        rd_data_b
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CW    = $clog2(WR_LAT + 1);

    logic [7:0]        mem [DEPTH];
    logic [CW-1:0]     cnt_q;
    logic [ADDR_W-1:0] lat_addr_q;
    logic [7:0]        lat_data_q;

    // Capture the request, count the latency, then commit the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cnt_q      <= '0;
            lat_addr_q <= '0;
            lat_data_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_start && !busy) begin
            busy       <= 1'b1;
            cnt_q      <= CW'(WR_LAT - 1);
            lat_addr_q <= wr_addr;
            lat_data_q <= wr_data;
        end else if (busy) begin
            if (cnt_q == '0) begin
                mem[lat_addr_q] <= lat_data_q;
                busy            <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign rd_data_a = mem[rd_addr_a];
    assign rd_data_b = mem[rd_addr_b];

    // R6
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> !busy);
endmodule

// File: rtl/nvm_ctl_top.sv
// Guarded write controller: register file, key gate, hold-off gate and
// external port gate around the behavioural array. Assumes ADDR_W <= 8.
module nvm_ctl_top
    import nvm_ctl_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int WR_LAT   = 20,
    parameter int PWRT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              code_protect,
    input  logic              xp_rd,
    input  logic              xp_wr,
    input  logic [ADDR_W-1:0] xp_addr,
    input  logic [7:0]        xp_wdata,
    output logic [7:0]        xp_rdata,
    output logic              xp_ack,
    output logic              xp_refused
);
    localparam int PAD_W = 8 - ADDR_W;

    logic              wen_q, err_q;
    logic [1:0]        msel_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic              busy, armed, hold_done;
    logic [7:0]        rd_a, rd_b;
    logic              ctrl_wr, sel_ok, cpu_rd, cpu_try, cpu_go, cpu_bad;
    logic              xp_open, xp_go, xp_take, arr_go;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0]        arr_data;

    nvm_pwrt #(.HOLD_CYC(PWRT_CYC)) u_pwrt (
        .clk(clk), .rst_n(rst_n), .done(hold_done));

    nvm_key_seq u_key (
        .clk(clk), .rst_n(rst_n),
        .key_wr(bus_we && bus_sel == OFS_KEY), .key_byte(bus_wdata),
        .other_wr(bus_we && (bus_sel == OFS_ADDR || bus_sel == OFS_DATA)),
        .consume(ctrl_wr), .armed(armed));

    nvm_array_model #(.ADDR_W(ADDR_W), .WR_LAT(WR_LAT)) u_arr (
        .clk(clk), .rst_n(rst_n), .wr_start(arr_go), .wr_addr(arr_addr),
        .wr_data(arr_data), .busy(busy), .rd_addr_a(addr_q), .rd_data_a(rd_a),
        .rd_addr_b(xp_addr), .rd_data_b(rd_b));

    // Decode processor requests and arbitrate the single array write slot.
    always_comb begin
        ctrl_wr  = bus_we && bus_sel == OFS_CTRL;
        sel_ok   = bus_wdata[B_SELH:B_SELL] == 2'b00;
        cpu_rd   = ctrl_wr && bus_wdata[B_RD] && sel_ok && !busy;
        cpu_try  = ctrl_wr && bus_wdata[B_GO] && sel_ok && !busy;
        cpu_go   = cpu_try && bus_wdata[B_WEN] && armed && hold_done;
        cpu_bad  = cpu_try && !cpu_go;
        xp_open  = !code_protect;
        xp_go    = xp_wr && xp_open && !busy && hold_done && !cpu_go;
        xp_take  = xp_open && (xp_rd || xp_go);
        arr_go   = cpu_go || xp_go;
        arr_addr = cpu_go ? addr_q : xp_addr;
        arr_data = cpu_go ? data_q : xp_wdata;
    end

    // Processor-visible register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q  <= 1'b0;
            err_q  <= 1'b0;
            msel_q <= 2'b00;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (ctrl_wr) begin
                wen_q  <= bus_wdata[B_WEN];
                msel_q <= bus_wdata[B_SELH:B_SELL];
                err_q  <= cpu_bad || (err_q && bus_wdata[B_ERR]);
            end
            if (bus_we && bus_sel == OFS_ADDR) addr_q <= bus_wdata[ADDR_W-1:0];
            if (bus_we && bus_sel == OFS_DATA) data_q <= bus_wdata;
            else if (cpu_rd)                   data_q <= rd_a;
        end
    end

    // External port response, one cycle after the request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xp_ack     <= 1'b0;
            xp_refused <= 1'b0;
            xp_rdata   <= '0;
        end else begin
            xp_ack     <= xp_take;
            xp_refused <= (xp_rd || xp_wr) && !xp_take;
            if (xp_rd && xp_open) xp_rdata <= rd_b;
        end
    end

    // Register read multiplexer.
    always_comb begin
        unique case (bus_sel)
            OFS_CTRL: bus_rdata = {2'b00, msel_q, err_q, busy, 1'b0, wen_q};
            OFS_KEY:  bus_rdata = 8'h00;
            OFS_ADDR: bus_rdata = {{PAD_W{1'b0}}, addr_q};
            default:  bus_rdata = data_q;
        endcase
    end

    // R2
    hold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(hold_done));

    // R3
    key_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(armed || xp_wr));

    // R10
    protect_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xp_ack |-> !$past(code_protect));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(u_arr.lat_addr_q));
endmodule

// File: tb/sim_nvm_ctl_top.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_nvm_ctl_top;
    localparam int AW = 8, LAT = 20, HOLD = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic code_protect = 1'b0, xp_rd = 1'b0, xp_wr = 1'b0;
    logic [AW-1:0] xp_addr = '0;
    logic [7:0] xp_wdata = 8'h00, xp_rdata;
    logic xp_ack, xp_refused;
    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    nvm_ctl_top #(.ADDR_W(AW), .WR_LAT(LAT), .PWRT_CYC(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .code_protect(code_protect),
        .xp_rd(xp_rd), .xp_wr(xp_wr), .xp_addr(xp_addr), .xp_wdata(xp_wdata),
        .xp_rdata(xp_rdata), .xp_ack(xp_ack), .xp_refused(xp_refused));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [1:0] r, input logic [7:0] v);
        @(negedge clk); bus_we = 1'b1; bus_sel = r; bus_wdata = v;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rr(input logic [1:0] r, output logic [7:0] v);
        @(negedge clk); bus_we = 1'b0; bus_sel = r; #1 v = bus_rdata;
    endtask

    task automatic unlock();
        bw(2'd1, 8'h55); bw(2'd1, 8'hAA);
    endtask

    task automatic cpu_write(input logic [7:0] a, input logic [7:0] d);
        bw(2'd2, a); bw(2'd3, d); unlock(); bw(2'd0, 8'h05);
    endtask

    task automatic wait_idle(output int polls);
        logic [7:0] v;
        polls = 0;
        rr(2'd0, v);
        while (v[2] && polls < 500) begin polls++; rr(2'd0, v); end
    endtask

    task automatic cpu_read(input logic [7:0] a, output logic [7:0] d);
        bw(2'd2, a); bw(2'd0, 8'h03); rr(2'd3, d);
    endtask

    task automatic xp_pulse(input bit wr, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); xp_rd = !wr; xp_wr = wr; xp_addr = a; xp_wdata = d;
        @(negedge clk); xp_rd = 1'b0; xp_wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rr(2'd0, v); chk("R1 ctrl", v, 8'h00);
        rr(2'd2, v); chk("R1 addr", v, 8'h00);
        rr(2'd3, v); chk("R1 data", v, 8'h00);
        bw(2'd1, 8'h55); rr(2'd1, v); chk("R12 key reads zero", v, 8'h00);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        int p;
        cpu_write(8'h05, 8'h3C);
        rr(2'd0, v); chk("R2 no busy in window", {7'd0, v[2]}, 8'd0);
        chk("R2 err in window", {7'd0, v[3]}, 8'd1);
        repeat (HOLD + 10) @(negedge clk);
        cpu_read(8'h05, v); chk("R2 byte untouched", v, 8'hFF);
        bw(2'd0, 8'h01); rr(2'd0, v); chk("R5 err cleared", v, 8'h01);
        cpu_write(8'h06, 8'h3C); wait_idle(p);
        cpu_read(8'h06, v); chk("R2 accepted after window", v, 8'h3C);
    endtask

    task automatic t_write();
        logic [7:0] v;
        int p;
        cpu_write(8'h10, 8'hA5);
        rr(2'd0, v); chk("R6 busy set", {7'd0, v[2]}, 8'd1);
        wait_idle(p);
        chk("R6 busy clears near latency", (p >= LAT - 4 && p <= LAT) ? 8'd1 : 8'd0, 8'd1);
        cpu_read(8'h10, v); chk("R3 programmed byte", v, 8'hA5);
        rr(2'd0, v); chk("R7 rd bit reads zero", {7'd0, v[1]}, 8'd0);
        cpu_read(8'h06, v); chk("R7 read other byte", v, 8'h3C);
    endtask

    task automatic t_latch();
        logic [7:0] v;
        int p;
        cpu_write(8'h20, 8'h11);
        bw(2'd2, 8'h21); bw(2'd3, 8'h99);
        wait_idle(p);
        cpu_read(8'h20, v); chk("R9 latched data", v, 8'h11);
        cpu_read(8'h21, v); chk("R9 new addr untouched", v, 8'hFF);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        int p;
        cpu_write(8'h30, 8'h77);
        bw(2'd2, 8'h31); bw(2'd3, 8'h66); unlock(); bw(2'd0, 8'h05);
        rr(2'd0, v); chk("R6 no err while busy", {7'd0, v[3]}, 8'd0);
        wait_idle(p);
        cpu_read(8'h31, v); chk("R6 start ignored while busy", v, 8'hFF);
        cpu_read(8'h30, v); chk("R6 first write kept", v, 8'h77);
    endtask

    task automatic t_bad_key();
        logic [7:0] v;
        bw(2'd2, 8'h40); bw(2'd3, 8'h5E);
        unlock(); bw(2'd0, 8'h04);
        rr(2'd0, v); chk("R5 wen clear err", v, 8'h08);
        bw(2'd0, 8'h01);
        bw(2'd1, 8'h55); bw(2'd1, 8'h12); bw(2'd1, 8'hAA); bw(2'd0, 8'h05);
        rr(2'd0, v); chk("R4 wrong byte breaks key", v, 8'h09);
        bw(2'd0, 8'h01);
        bw(2'd1, 8'h55); bw(2'd3, 8'h5E); bw(2'd1, 8'hAA); bw(2'd0, 8'h05);
        rr(2'd0, v); chk("R4 data write breaks key", v, 8'h09);
        bw(2'd0, 8'h01);
        unlock(); bw(2'd0, 8'h01); bw(2'd0, 8'h05);
        rr(2'd0, v); chk("R4 key used by ctrl write", v, 8'h09);
        bw(2'd0, 8'h01);
        cpu_read(8'h40, v); chk("R5 byte untouched", v, 8'hFF);
    endtask

    task automatic t_select();
        logic [7:0] v;
        bw(2'd2, 8'h50); bw(2'd3, 8'h5A); unlock(); bw(2'd0, 8'h15);
        rr(2'd0, v); chk("R8 other memory no start", v, 8'h11);
        bw(2'd0, 8'h13); rr(2'd3, v); chk("R8 other memory no read", v, 8'h5A);
        cpu_read(8'h50, v); chk("R8 byte untouched", v, 8'hFF);
    endtask

    task automatic t_xport();
        logic [7:0] v;
        int p;
        code_protect = 1'b1;
        xp_pulse(1'b0, 8'h10, 8'h00);
        chk("R10 read refused", {6'd0, xp_ack, xp_refused}, 8'd1);
        xp_pulse(1'b1, 8'h60, 8'h42);
        chk("R10 write refused", {6'd0, xp_ack, xp_refused}, 8'd1);
        rr(2'd0, v); chk("R10 no busy", {7'd0, v[2]}, 8'd0);
        cpu_write(8'h61, 8'h24); wait_idle(p);
        cpu_read(8'h61, v); chk("R10 cpu write under protect", v, 8'h24);
        code_protect = 1'b0;
        xp_pulse(1'b0, 8'h60, 8'h00);
        chk("R10 refused write left byte", xp_rdata, 8'hFF);
        chk("R11 read ack", {6'd0, xp_ack, xp_refused}, 8'd2);
        xp_pulse(1'b0, 8'h10, 8'h00);
        chk("R11 read data", xp_rdata, 8'hA5);
        xp_pulse(1'b1, 8'h62, 8'h81);
        chk("R11 write ack", {6'd0, xp_ack, xp_refused}, 8'd2);
        xp_pulse(1'b1, 8'h63, 8'h18);
        chk("R11 refused while busy", {6'd0, xp_ack, xp_refused}, 8'd1);
        wait_idle(p);
        xp_pulse(1'b0, 8'h62, 8'h00);
        chk("R11 written byte", xp_rdata, 8'h81);
        xp_pulse(1'b0, 8'h63, 8'h00);
        chk("R11 busy write dropped", xp_rdata, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hold();
        t_write();
        t_latch();
        t_busy_ignore();
        t_bad_key();
        t_select();
        t_xport();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule